// File: doc/BRIEF.md
# Command mailbox responder

This block is the device-side end of a register mailbox. A host sends short commands through it and reads multi-word results back. The host sees three registers and a data window on a simple 32-bit word-addressed write bus with a combinational read path. The command register holds a command code and a queue index. The status register carries a word count, a busy flag, a chunk-ready flag and an error code. The data window holds the current chunk of result words. On the other side, the block hands each decoded command to a backend through a valid/ready handshake. It then accepts result words from the backend as a stream, together with a last marker and an optional error code.

A sequencer splits the result into chunks. Each chunk is at most the window depth and at most the number of words the host still expects. The sequencer publishes each chunk and then waits for the host to acknowledge it before it refills the window. A command with no payload is answered with an empty chunk. The block signals completion by clearing the command register, and it drops any result words beyond the requested count. A compatibility mode uses the command register alone: a command is acknowledged only by that register being cleared, and the status register is left untouched.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the command register (word 0) and the status register (word 1) read zero and `cmd_valid` is low.
- R2: In normal mode, a nonzero write to word 0 while idle starts a command. `cmd_valid` stays high until `cmd_ready`. `cmd_code` carries write bits 15:0, `cmd_qidx` carries bits 31:16, and `cmd_len` carries the word count held in status bits 15:0. Status bit 16 (busy) reads 1 from the cycle after the write.
- R3: Each published chunk carries min(DEPTH, words still owed) words. Word i of the chunk is at word address 3+i. The status register reports the count in bits 15:0 and sets bit 17 (chunk ready). Bit 16 stays 1 while more chunks follow.
- R4: After a non-final chunk is published, no backend word is accepted (`res_ready` low) and the status word stays unchanged until the host writes word 1 with bit 17 equal to 0.
- R5: The final chunk is published with bit 16 cleared. Word 0 reads zero once the command has fully finished.
- R6: A command requesting zero words is answered with bit 17 set, a count of 0 and bit 16 cleared, and word 0 then clears.
- R7: A backend beat with a nonzero `res_err` ends the command. Status bits 27:18 hold the code, bit 17 is 1, bit 16 is 0, the count is the number of words stored in that chunk, and word 0 clears.
- R8: If the backend marks its last word early, the final chunk is short. If it sends more words than requested, the extra words are accepted and dropped, and word 0 clears only after the backend's last word.
- R9: While a command is active, writes to word 0 are ignored, as are status writes that keep bit 17 set.
- R10: Reads of word 2, and of window words at or beyond the current chunk count, return zero.
- R11: With `legacy_mode` high at the start, a command is sent with `cmd_len` 0 and the status register is not changed. Word 0 clears after the backend's last word.
- R12: A write to word 1 while idle loads bits 15:0 as the requested count and clears bits 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Selects the single-register command mode, sampled at command start |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | ADDR_W | Word address (0 command, 1 status, 2 reserved, 3+ window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word` |
| cmd_valid | output | 1 | Decoded command offered to the backend |
| cmd_ready | input | 1 | Backend takes the command |
| cmd_code | output | 16 | Command code |
| cmd_qidx | output | 16 | Queue index |
| cmd_len | output | 16 | Requested result words |
| res_valid | input | 1 | Backend result beat valid |
| res_ready | output | 1 | Block accepts a result beat |
| res_data | input | 32 | Result word |
| res_last | input | 1 | Last beat of this command |
| res_err | input | 10 | Nonzero ends the command with this error code |

## Verification
The bench targets chunk boundaries. A result of exactly one window must come back as a single final chunk, not as a full chunk followed by an empty one. A result of several windows must leave a short tail, and a design with an off-by-one count would show a wrong size or a stray extra chunk. While the host holds a chunk without acknowledging it, the bench checks that the window is not overwritten, that a stray command write does not launch a second command, and that an acknowledgement with the ready bit still set is not taken as real. It also covers an early error, an over-long backend stream that must be drained before completion, empty commands, and compatibility mode, where a design that touched the status word would corrupt the host's count.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 32;
    localparam int ERR_W  = 10;

    // Status word layout, MSB first (bits 31:28, 27:18, 17, 16, 15:0)
    typedef struct packed {
        logic [3:0]       spare;
        logic [ERR_W-1:0] err;
        logic             rdy;
        logic             busy;
        logic [15:0]      size;
    } mbx_stat_t;

    typedef struct packed {
        logic [15:0] qidx;
        logic [15:0] code;
    } mbx_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FILL,
        ST_HOLD,
        ST_DRAIN
    } mbx_state_e;

    typedef enum logic [1:0] {
        RG_OP,
        RG_CTRL,
        RG_RSVD,
        RG_DATA
    } mbx_reg_e;

    function automatic mbx_reg_e reg_of(input logic [15:0] word);
        case (word)
            16'd0:   reg_of = RG_OP;
            16'd1:   reg_of = RG_CTRL;
            16'd2:   reg_of = RG_RSVD;
            default: reg_of = RG_DATA;
        endcase
    endfunction

endpackage

// File: rtl/mbx_window.sv
module mbx_window #(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [mbx_pkg::WORD_W-1:0] wr_data,
    input  logic [15:0]               rd_off,
    input  logic [15:0]               valid_cnt,
    output logic [mbx_pkg::WORD_W-1:0] rd_data
);
    logic [mbx_pkg::WORD_W-1:0] slot_q [DEPTH];
    logic in_range;

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (rst)
                slot_q[s] <= '0;
            else if (wr_en && wr_idx == IDX_W'(s))
                slot_q[s] <= wr_data;
        end
    end

    assign in_range = (rd_off < valid_cnt) && (rd_off < 16'(DEPTH));
    assign rd_data  = in_range ? slot_q[rd_off[IDX_W-1:0]] : '0;

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode,
    input  logic              op_wr,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] wdata,
    output mbx_op_t           op_q,
    output mbx_stat_t         stat_q,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [15:0]       cmd_code,
    output logic [15:0]       cmd_qidx,
    output logic [15:0]       cmd_len,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [WORD_W-1:0] res_data,
    input  logic              res_last,
    input  logic [ERR_W-1:0]  res_err,
    output logic              win_we,
    output logic [IDX_W-1:0]  win_idx,
    output logic [WORD_W-1:0] win_data
);
    mbx_state_e       state_q;
    logic [15:0]      rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lg_q;

    logic             beat, store, bad, final_c, chunk_end;
    logic [CNT_W-1:0] cnt_nx;
    logic [15:0]      rem_nx;

    assign res_ready = (state_q == ST_FILL) || (state_q == ST_DRAIN);
    assign beat      = res_valid && res_ready;
    assign bad       = res_err != '0;
    assign store     = beat && (state_q == ST_FILL) && (rem_q != '0) && !bad;
    assign cnt_nx    = cnt_q + CNT_W'(store);
    assign rem_nx    = rem_q - 16'(store);
    assign final_c   = res_last || (rem_nx == '0);
    assign chunk_end = final_c || (cnt_nx == CNT_W'(DEPTH));

    assign cmd_valid = (state_q == ST_ISSUE);
    assign cmd_code  = op_q.code;
    assign cmd_qidx  = op_q.qidx;
    assign cmd_len   = rem_q;

    assign win_we    = store;
    assign win_idx   = cnt_q[IDX_W-1:0];
    assign win_data  = res_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            stat_q  <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            lg_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (op_wr && wdata != '0) begin
                        op_q  <= wdata;
                        lg_q  <= legacy_mode;
                        cnt_q <= '0;
                        rem_q <= legacy_mode ? 16'd0 : stat_q.size;
                        if (!legacy_mode)
                            stat_q <= '{spare: '0, err: '0, rdy: 1'b0, busy: 1'b1, size: '0};
                        state_q <= ST_ISSUE;
                    end else if (ctrl_wr) begin
                        stat_q <= '{spare: '0, err: '0, rdy: 1'b0, busy: 1'b0, size: wdata[15:0]};
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready)
                        state_q <= ST_FILL;
                end
                ST_FILL: begin
                    if (beat) begin
                        rem_q <= rem_nx;
                        if (bad) begin
                            if (!lg_q)
                                stat_q <= '{spare: '0, err: res_err, rdy: 1'b1, busy: 1'b0,
                                            size: 16'(cnt_nx)};
                            cnt_q   <= '0;
                            op_q    <= '0;
                            state_q <= ST_IDLE;
                        end else if (chunk_end) begin
                            if (!lg_q)
                                stat_q <= '{spare: '0, err: '0, rdy: 1'b1, busy: !final_c,
                                            size: 16'(cnt_nx)};
                            cnt_q <= '0;
                            if (!final_c) begin
                                state_q <= ST_HOLD;
                            end else if (res_last) begin
                                op_q    <= '0;
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_DRAIN;
                            end
                        end else begin
                            cnt_q <= cnt_nx;
                        end
                    end
                end
                ST_HOLD: begin
                    if (ctrl_wr && !wdata[17]) begin
                        stat_q.rdy <= 1'b0;
                        state_q    <= ST_FILL;
                    end
                end
                ST_DRAIN: begin
                    if (beat && res_last) begin
                        op_q    <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: a published chunk never exceeds the window
    a_r3_chunk_bound: assert property (@(posedge clk) disable iff (rst)
        stat_q.rdy |-> (stat_q.size <= 16'(DEPTH)));

    // R4: no backend word is taken while a non-final chunk waits for the host
    a_r4_hold_no_accept: assert property (@(posedge clk) disable iff (rst)
        (stat_q.rdy && stat_q.busy) |-> !res_ready);

    // R7: an error code always comes with the busy flag down
    a_r7_err_terminal: assert property (@(posedge clk) disable iff (rst)
        (stat_q.err != '0) |-> !stat_q.busy);

    // R9: a live command register only keeps its value or clears
    a_r9_op_frozen: assert property (@(posedge clk) disable iff (rst)
        (op_q != '0) |=> ((op_q == '0) || (op_q == $past(op_q))));

    // R2: an offered command is held until taken
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(op_q)));

    // R11: compatibility-mode commands leave the status word alone
    a_r11_stat_untouched: assert property (@(posedge clk) disable iff (rst)
        (lg_q && state_q != ST_IDLE) |=> $stable(stat_q));

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int ADDR_W = 5,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [15:0]       cmd_code,
    output logic [15:0]       cmd_qidx,
    output logic [15:0]       cmd_len,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [31:0]       res_data,
    input  logic              res_last,
    input  logic [9:0]        res_err
);
    mbx_op_t     op_q;
    mbx_stat_t   stat_q;
    mbx_reg_e    sel;
    logic [15:0] word16, win_off;
    logic        win_we;
    logic [IDX_W-1:0]  win_idx;
    logic [WORD_W-1:0] win_wdata, win_rdata;

    assign word16  = 16'(bus_word);
    assign win_off = word16 - 16'd3;
    assign sel     = reg_of(word16);

    mbx_seq #(.DEPTH(DEPTH)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .legacy_mode(legacy_mode),
        .op_wr      (bus_wr && sel == RG_OP),
        .ctrl_wr    (bus_wr && sel == RG_CTRL),
        .wdata      (bus_wdata),
        .op_q       (op_q),
        .stat_q     (stat_q),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_code   (cmd_code),
        .cmd_qidx   (cmd_qidx),
        .cmd_len    (cmd_len),
        .res_valid  (res_valid),
        .res_ready  (res_ready),
        .res_data   (res_data),
        .res_last   (res_last),
        .res_err    (res_err),
        .win_we     (win_we),
        .win_idx    (win_idx),
        .win_data   (win_wdata)
    );

    mbx_window #(.DEPTH(DEPTH)) win_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (win_we),
        .wr_idx   (win_idx),
        .wr_data  (win_wdata),
        .rd_off   (win_off),
        .valid_cnt(stat_q.size),
        .rd_data  (win_rdata)
    );

    always_comb begin
        case (sel)
            RG_OP:   bus_rdata = op_q;
            RG_CTRL: bus_rdata = stat_q;
            RG_DATA: bus_rdata = win_rdata;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb_top;
    localparam int DEPTH = 16;
    localparam int AW    = 5;
    localparam logic [15:0] C_DESTROY = 16'd1, C_QSTATE = 16'd2,
                            C_SUSPEND = 16'd3, C_RESUME = 16'd4;

    logic clk = 1'b0, rst = 1'b1, legacy_mode = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_word = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic          cmd_valid, cmd_ready = 1'b0;
    logic [15:0]   cmd_code, cmd_qidx, cmd_len;
    logic          res_valid = 1'b0, res_ready, res_last = 1'b0;
    logic [31:0]   res_data = '0;
    logic [9:0]    res_err = '0;

    cmd_mailbox #(.DEPTH(DEPTH), .ADDR_W(AW)) dut_i (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int be_beats = 1;
    logic [9:0] be_err = '0;
    int cmd_count = 0;
    logic [15:0] got_code = '0, got_qidx = '0, got_len = '0;

    function automatic logic [31:0] word_of(input logic [15:0] q, input int k);
        return {q[7:0] + 8'h5A, 8'h00, 16'(k)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // backend model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmd_valid) begin
                cmd_ready = 1'b1;
                got_code = cmd_code; got_qidx = cmd_qidx; got_len = cmd_len;
                cmd_count++;
                @(negedge clk);
                cmd_ready = 1'b0;
                for (int k = 0; k < be_beats; k++) begin
                    res_valid = 1'b1;
                    res_data  = word_of(got_qidx, k);
                    res_last  = (k == be_beats - 1);
                    res_err   = (k == be_beats - 1) ? be_err : '0;
                    #1;
                    while (!res_ready) begin @(negedge clk); #1; end
                    @(negedge clk);
                end
                res_valid = 1'b0; res_last = 1'b0; res_err = '0;
            end
        end
    end

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_word = AW'(w); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_word = AW'(w);
        #1 d = bus_rdata;
    endtask

    task automatic wait_ready(input string tag, output logic [31:0] v);
        int n = 0;
        rd(1, v);
        while (!(v[17] || v[27:18] != 0) && n < 1000) begin rd(1, v); n++; end
        if (n >= 1000) check({tag, " timeout waiting chunk"}, 0, 1);
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        int n = 0;
        rd(0, v);
        while (v != 0 && n < 1000) begin rd(0, v); n++; end
        check({tag, " command register cleared"}, v, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v); check("R1 command reg after reset", v, 0);
        rd(1, v); check("R1 status reg after reset", v, 0);
        check("R1 cmd_valid after reset", 32'(cmd_valid), 0);
        rd(2, v); check("R10 reserved word reads zero", v, 0);
    endtask

    // generic read / no-payload flow
    task automatic t_cmd(input logic [15:0] code, input logic [15:0] q, input int len,
                         input int beats, input bit poke);
        logic [31:0] v, w;
        int total, rem, sz, done = 0, c0 = cmd_count;
        string tg;
        be_beats = beats; be_err = '0;
        tg = (len == 0) ? "R6" : "R3";
        wr(1, 32'(len));
        wr(0, {q, code});
        rd(1, v); check("R2 busy bit after start", 32'(v[16]), 1);
        total = (len < beats) ? len : beats;
        rem = total;
        forever begin
            wait_ready(tg, v);
            sz = (rem < DEPTH) ? rem : DEPTH;
            rem -= sz;
            check({tg, " chunk size"}, 32'(v[15:0]), 32'(sz));
            check({tg, " chunk ready"}, 32'(v[17]), 1);
            check(rem == 0 ? "R5 busy on final chunk" : "R3 busy on inner chunk",
                  32'(v[16]), 32'(rem != 0));
            check({tg, " no error"}, 32'(v[27:18]), 0);
            for (int i = 0; i < sz; i++) begin
                rd(3 + i, w);
                check("R3 window word", w, word_of(q, done + i));
            end
            if (sz < DEPTH) begin
                rd(3 + sz, w); check("R10 word past chunk reads zero", w, 0);
            end
            done += sz;
            if (rem == 0) break;
            if (poke) begin
                repeat (20) @(negedge clk);
                check("R4 no accept while held", 32'(res_ready), 0);
                rd(1, w); check("R4 status held", w, v);
                wr(0, 32'h0000_0003);
                rd(0, w); check("R9 command write ignored", w, {q, code});
                wr(1, v);
                rd(1, w); check("R9 ack with ready bit set ignored", w, v);
                poke = 1'b0;
            end
            wr(1, v & ~32'h0002_0000);
        end
        wait_done(rem == 0 ? "R5" : "R5");
        check("R2 one command issued", 32'(cmd_count), 32'(c0 + 1));
        check("R2 code", 32'(got_code), 32'(code));
        check("R2 queue index", 32'(got_qidx), 32'(q));
        check("R2 length", 32'(got_len), 32'(len));
        if (beats > len) check("R8 extra words drained", 32'(res_valid), 0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        be_beats = 3; be_err = 10'h155;
        wr(1, 32'd8);
        wr(0, {16'd7, C_QSTATE});
        wait_ready("R7", v);
        check("R7 error field", 32'(v[27:18]), 32'h155);
        check("R7 busy cleared", 32'(v[16]), 0);
        check("R7 stored count", 32'(v[15:0]), 2);
        rd(4, v); check("R7 stored word 1", v, word_of(16'd7, 1));
        wait_done("R7");
        be_err = '0;
        wr(1, 32'h0000_0005);
        rd(1, v); check("R12 idle status write", v, 32'h0000_0005);
    endtask

    task automatic t_legacy();
        logic [31:0] v;
        int c0 = cmd_count;
        be_beats = 1; be_err = '0;
        wr(1, 32'h0000_0007);
        legacy_mode = 1'b1;
        wr(0, 32'(C_RESUME));
        wait_done("R11");
        rd(1, v); check("R11 status untouched", v, 32'h0000_0007);
        check("R11 one command", 32'(cmd_count), 32'(c0 + 1));
        check("R11 zero length offered", 32'(got_len), 0);
        legacy_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cmd(C_QSTATE, 16'h0011, 40, 40, 1'b1);
        t_cmd(C_QSTATE, 16'h0022, 16, 16, 1'b0);
        t_cmd(C_QSTATE, 16'h0033, 20, 5, 1'b0);
        t_cmd(C_QSTATE, 16'h0044, 6, 12, 1'b0);
        t_cmd(C_DESTROY, 16'h0000, 0, 1, 1'b0);
        t_cmd(C_SUSPEND, 16'h0000, 0, 1, 1'b0);
        t_error();
        t_legacy();
        t_cmd(C_RESUME, 16'h0000, 0, 1, 1'b0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule